// File: doc/BRIEF.md
# Multi-channel reloadable down-counter timer

The block holds two or three independent 32-bit down-counting timer channels behind a simple register bus. The bus has a byte address, a write strobe, byte enables and 32-bit write data, and its read data is combinational. Each channel has three registers: a reload constant, a live counter and a control word. A shared start byte holds one run bit per channel. A single free-running prescaler serves every channel. Each channel picks one of its taps: divide by 4, 16, 64, 256 or 1024.

A running channel decrements its counter on each tick of its selected tap. On the tick after the counter has reached zero, the channel reloads the counter from the constant and sets its underflow flag. The channel's interrupt output is raised while both the flag and the interrupt enable are set.

- **Periodic events:** software writes the same value into the constant and the counter.
- **One-shot events:** software writes the delay into the counter and all-ones into the constant.
- **Free-running time base:** the constant is all-ones, and the inverted counter value rises steadily.

A parameter selects an alternate register layout.

Top module: `reload_timer_unit`

## Requirements
- R1: After reset the run bits read 0, every constant and counter reads 0xFFFFFFFF, every control word reads 0, and all interrupt outputs are low.
- R2: In the default layout the start byte is bits 7:0 of the word at byte address 4. Channel n occupies byte addresses 8+12n (constant), 12+12n (counter) and 16+12n (control). Start bits at or above the channel count read 0.
- R3: Setting start bit n runs channel n. Clearing it stops the channel, and a stopped channel holds its counter value.
- R4: Control bits 2:0 select the tap. Codes 0, 1, 2, 3 and 4 select divide by 4, 16, 64, 256 and 1024, and codes 5 to 7 behave as code 0. The prescaler is shared and counts from reset. A channel steps on clock edge e after reset (counting from 0) exactly when e mod N equals N-1, so a channel running for N·k edges steps k times.
- R5: Each step decrements the counter by one. A step taken while the counter is 0 instead reloads the counter from the constant held before that edge and sets the underflow flag, control bit 8.
- R6: Writing the control word with byte 1 enabled and bit 8 at 0 clears the flag. Writing bit 8 as 1 leaves the flag unchanged. An underflow on the same edge as a clear leaves the flag set.
- R7: Control bit 5 is the interrupt enable. The interrupt output of channel n is high exactly when its flag and its enable are both set.
- R8: A counter write takes effect on the next edge whether the channel runs or not. It takes priority over a step on that edge, and that step neither reloads nor sets the flag. Writing the constant never changes the counter.
- R9: Only the byte lanes whose enable is set are written; the other bytes keep their values.
- R10: With the alternate layout the start byte is bits 23:16 of the word at byte address 0. Channel n's block then begins at byte address 4+12n.
- R11: Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
The bench goes after the reload edge, where a design that decrements past zero would wrap to 0xFFFFFFFF instead of loading the constant. It also targets the prescaler phase: an off-by-one tap would make the step count over a window of N·k edges come out wrong. Flag handling is checked for sticky set, clear-by-zero and the interrupt enable gate; a flag that toggles on a written 1 or an interrupt that ignores the enable shows up on the interrupt outputs. Partial byte writes, the unused start bits and the alternate layout are probed, so a misplaced lane or base offset reads back a wrong word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned BE_W      = DATA_W / 8;
   localparam int unsigned TAP_COUNT = 5;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned IE_BIT    = 5;
   localparam int unsigned UF_BIT    = 8;
   localparam int unsigned WORDS_PER_CH = 3;

   typedef enum logic [SEL_W-1:0] {
      TAP_DIV4    = 3'd0,
      TAP_DIV16   = 3'd1,
      TAP_DIV64   = 3'd2,
      TAP_DIV256  = 3'd3,
      TAP_DIV1024 = 3'd4
   } tap_sel_e;

   // reserved codes fall back to the fastest tap
   function automatic logic [SEL_W-1:0] tap_index(input logic [SEL_W-1:0] code);
      return (code > TAP_DIV1024) ? TAP_DIV4 : code;
   endfunction

   function automatic logic [DATA_W-1:0] merge_lanes(
      input logic [DATA_W-1:0] old_v,
      input logic [DATA_W-1:0] new_v,
      input logic [BE_W-1:0]   be);
      logic [DATA_W-1:0] res;
      res = old_v;
      for (int b = 0; b < BE_W; b++)
         if (be[b]) res[8*b +: 8] = new_v[8*b +: 8];
      return res;
   endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned TAPS = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TAPS-1:0] tick
);
   localparam int unsigned PW = 2 * TAPS;

   logic [PW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign tick[i] = &div_q[2*i+1:0];
      if (i > 0) begin : g_nest
         // a slower tap only fires on an edge where every faster tap fires
         p_tap_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tick[i] |-> tick[i-1]);
      end
   end
endmodule

// File: rtl/tmr_start_reg.sv
module tmr_start_reg #(
   parameter int unsigned NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [7:0]        wbyte,
   output logic [NUM_CH-1:0] run
);
   logic unused_hi_bits;
   assign unused_hi_bits = ^wbyte[7:NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  run <= '0;
      else if (we) run <= wbyte[NUM_CH-1:0];
   end

   p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(run));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int unsigned TAPS = TAP_COUNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [TAPS-1:0]   tick,
   input  logic              we_const,
   input  logic              we_count,
   input  logic              we_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   be,
   output logic [DATA_W-1:0] const_q,
   output logic [DATA_W-1:0] count_q,
   output logic [DATA_W-1:0] ctrl_word,
   output logic              irq
);
   logic [SEL_W-1:0] sel_q;
   logic             ie_q;
   logic             uf_q;
   logic             step;
   logic             at_zero;
   logic             wrap;
   logic             clr_req;

   assign step    = run & tick[tap_index(sel_q)];
   assign at_zero = (count_q == '0);
   assign wrap    = step & at_zero & ~we_count;
   assign clr_req = we_ctrl & be[UF_BIT/8] & ~wdata[UF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        const_q <= '1;
      else if (we_const) const_q <= merge_lanes(const_q, wdata, be);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count_q <= '1;
      else if (we_count) count_q <= merge_lanes(count_q, wdata, be);
      else if (step)     count_q <= at_zero ? const_q : count_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= TAP_DIV4;
         ie_q  <= 1'b0;
      end else if (we_ctrl && be[0]) begin
         sel_q <= wdata[SEL_W-1:0];
         ie_q  <= wdata[IE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       uf_q <= 1'b0;
      else if (wrap)    uf_q <= 1'b1;
      else if (clr_req) uf_q <= 1'b0;
   end

   always_comb begin
      ctrl_word              = '0;
      ctrl_word[SEL_W-1:0]   = sel_q;
      ctrl_word[IE_BIT]      = ie_q;
      ctrl_word[UF_BIT]      = uf_q;
   end

   assign irq = uf_q & ie_q;

   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !we_count) |=> $stable(count_q));

   p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !at_zero && !we_count) |=> count_q == $past(count_q) - 1'b1);

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_zero && !we_count) |=> (count_q == $past(const_q)) && uf_q);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_q && !clr_req) |=> uf_q);

   p_count_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_count && be == '1) |=> count_q == $past(wdata));
endmodule

// File: rtl/reload_timer_unit.sv
module reload_timer_unit
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH  = 3,
   parameter bit          ALT_MAP = 1'b0,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [BE_W-1:0]     bus_be,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_CH-1:0]   irq
);
   localparam int unsigned START_BYTE = ALT_MAP ? 2 : 4;
   localparam int unsigned START_WORD = START_BYTE / 4;
   localparam int unsigned START_LANE = START_BYTE % 4;
   localparam int unsigned CH_BASE    = ALT_MAP ? 4 : 8;
   localparam int unsigned CH_WORD0   = CH_BASE / 4;
   localparam int unsigned MAP_END    = CH_BASE + 4 * WORDS_PER_CH * NUM_CH;

   if (NUM_CH < 2 || NUM_CH > 3) begin : g_bad_count
      $error("reload_timer_unit: NUM_CH must be 2 or 3");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("reload_timer_unit: ADDR_W too small for the register map");
   end

   logic [31:0]       word_idx;
   logic              unused_addr_lsb;
   logic [NUM_CH-1:0] run;
   logic [TAP_COUNT-1:0] tick;
   logic              start_hit;
   logic [DATA_W-1:0] ch_rd [NUM_CH];

   assign word_idx        = 32'(bus_addr[ADDR_W-1:2]);
   assign unused_addr_lsb = ^bus_addr[1:0];
   assign start_hit       = (word_idx == 32'(START_WORD));

   tmr_prescaler #(.TAPS(TAP_COUNT)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   tmr_start_reg #(.NUM_CH(NUM_CH)) u_start (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bus_wr & start_hit & bus_be[START_LANE]),
      .wbyte(bus_wdata[8*START_LANE +: 8]),
      .run  (run)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int unsigned W0 = CH_WORD0 + WORDS_PER_CH * n;
      logic hit_const, hit_count, hit_ctrl;
      logic [DATA_W-1:0] const_q, count_q, ctrl_word;

      assign hit_const = (word_idx == 32'(W0));
      assign hit_count = (word_idx == 32'(W0 + 1));
      assign hit_ctrl  = (word_idx == 32'(W0 + 2));

      tmr_channel #(.TAPS(TAP_COUNT)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run[n]),
         .tick     (tick),
         .we_const (bus_wr & hit_const),
         .we_count (bus_wr & hit_count),
         .we_ctrl  (bus_wr & hit_ctrl),
         .wdata    (bus_wdata),
         .be       (bus_be),
         .const_q  (const_q),
         .count_q  (count_q),
         .ctrl_word(ctrl_word),
         .irq      (irq[n])
      );

      assign ch_rd[n] = hit_const ? const_q :
                        hit_count ? count_q :
                        hit_ctrl  ? ctrl_word : '0;
   end

   always_comb begin
      bus_rdata = '0;
      if (start_hit) bus_rdata[8*START_LANE +: 8] = 8'(run);
      for (int n = 0; n < NUM_CH; n++) bus_rdata = bus_rdata | ch_rd[n];
   end

   // R11: nothing outside the map may drive read data
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (word_idx >= 32'(MAP_END / 4)) |-> (bus_rdata == '0));
endmodule

// File: tb/test_reload_timer_unit.sv
module test_reload_timer_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   logic [7:0]  a_addr = '0;
   logic        a_wr = 1'b0;
   logic [3:0]  a_be = '0;
   logic [31:0] a_wdata = '0;
   logic [31:0] a_rdata;
   logic [1:0]  a_irq;

   int vectors = 0;
   int misses = 0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   reload_timer_unit #(.NUM_CH(3), .ALT_MAP(1'b0), .ADDR_W(8)) i_reload_timer_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   reload_timer_unit #(.NUM_CH(2), .ALT_MAP(1'b1), .ADDR_W(8)) i_reload_timer_unit_alt (
      .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr),
      .bus_be(a_be), .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq(a_irq));

   // ---------------- behavioural reference for the default instance
   logic [31:0] m_const [3];
   logic [31:0] m_cnt   [3];
   logic [2:0]  m_sel   [3];
   bit          m_ie    [3];
   bit          m_uf    [3];
   logic [2:0]  m_run = '0;
   int unsigned edge_n = 0;

   function automatic int unsigned div_of(input logic [2:0] c);
      case (c)
         3'd1: return 16;
         3'd2: return 64;
         3'd3: return 256;
         3'd4: return 1024;
         default: return 4;
      endcase
   endfunction

   function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d,
                                       input logic [3:0] be);
      logic [31:0] r;
      r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int unsigned w;
      w = 32'(a) >> 2;
      if (w == 1) return {29'd0, m_run};
      for (int n = 0; n < 3; n++) begin
         if (w == 2 + 3*n) return m_const[n];
         if (w == 3 + 3*n) return m_cnt[n];
         if (w == 4 + 3*n) return {23'd0, m_uf[n], 2'd0, m_ie[n], 2'd0, m_sel[n]};
      end
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 3; n++) begin
            m_const[n] = '1; m_cnt[n] = '1; m_sel[n] = '0; m_ie[n] = 0; m_uf[n] = 0;
         end
         m_run  = '0;
         edge_n = 0;
      end else begin
         int unsigned w;
         w = 32'(bus_addr) >> 2;
         for (int n = 0; n < 3; n++) begin
            bit tk, wrapped;
            int unsigned dv;
            dv = div_of(m_sel[n]);
            tk = m_run[n] && ((edge_n % dv) == dv - 1);
            wrapped = 0;
            if (bus_wr && w == 3 + 3*n) m_cnt[n] = mrg(m_cnt[n], bus_wdata, bus_be);
            else if (tk) begin
               if (m_cnt[n] == 0) begin m_cnt[n] = m_const[n]; wrapped = 1; end
               else m_cnt[n] = m_cnt[n] - 1;
            end
            if (bus_wr && w == 2 + 3*n) m_const[n] = mrg(m_const[n], bus_wdata, bus_be);
            if (wrapped) m_uf[n] = 1;
            else if (bus_wr && w == 4 + 3*n && bus_be[1] && !bus_wdata[8]) m_uf[n] = 0;
            if (bus_wr && w == 4 + 3*n && bus_be[0]) begin
               m_sel[n] = bus_wdata[2:0];
               m_ie[n]  = bus_wdata[5];
            end
         end
         if (bus_wr && w == 1 && bus_be[0]) m_run = bus_wdata[2:0];
         edge_n++;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison, sampled 2 ns before the next rising edge
   always begin
      @(posedge clk);
      #6;
      if (cmp_on) begin
         check("R2/R5 read word vs model", bus_rdata, m_read(bus_addr));
         check("R7 irq vs model", {29'd0, irq},
               {29'd0, 1'(m_uf[2] & m_ie[2]), 1'(m_uf[1] & m_ie[1]), 1'(m_uf[0] & m_ie[0])});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic awr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      a_addr = a; a_wdata = d; a_be = be; a_wr = 1'b1;
      @(negedge clk);
      a_wr = 1'b0; a_be = '0;
   endtask

   task automatic ard(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      a_addr = a;
      #1 d = a_rdata;
   endtask

   // run channel mask for exactly nedges clock edges, then stop all
   task automatic run_for(input logic [2:0] mask, input int nedges);
      wr(8'd4, {29'd0, mask}, 4'b0001);
      repeat (nedges - 1) @(posedge clk);
      wr(8'd4, 32'd0, 4'b0001);
   endtask

   task automatic step_test(input string tag, input logic [2:0] code, input int k);
      logic [31:0] v;
      wr(8'd16, {29'd0, code}, 4'b1111);
      wr(8'd12, 32'd1000, 4'b1111);
      run_for(3'b001, div_of(code) * k);
      rd(8'd12, v);
      check(tag, v, 32'd1000 - 32'(k));
   endtask

   initial begin
      #(8 * 150000);
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R1 reset state
      rd(8'd8,  v); check("R1 constant reset", v, 32'hFFFF_FFFF);
      rd(8'd12, v); check("R1 counter reset", v, 32'hFFFF_FFFF);
      rd(8'd16, v); check("R1 control reset", v, 32'd0);
      rd(8'd4,  v); check("R1 start reset", v, 32'd0);
      check("R1 irq reset", {29'd0, irq}, 32'd0);

      // R11 unmapped space
      rd(8'd0, v); check("R11 unmapped read", v, 32'd0);
      wr(8'd0, 32'hFFFF_FFFF, 4'b1111);
      wr(8'd60, 32'h1234_5678, 4'b1111);
      rd(8'd0, v); check("R11 unmapped write ignored", v, 32'd0);
      rd(8'd8, v); check("R11 neighbour untouched", v, 32'hFFFF_FFFF);

      // R2 map and unused start bits
      wr(8'd4, 32'h0000_00FF, 4'b0001);
      rd(8'd4, v); check("R2 start bits above count read 0", v, 32'd7);
      wr(8'd4, 32'd0, 4'b0001);
      wr(8'd20, 32'h0000_1234, 4'b1111);
      rd(8'd20, v); check("R2 channel 1 constant", v, 32'h0000_1234);
      wr(8'd40, 32'h0000_0023, 4'b1111);
      rd(8'd40, v); check("R2 channel 2 control", v, 32'h0000_0023);

      // R9 byte lanes
      wr(8'd8, 32'hAABB_CCDD, 4'b0010);
      rd(8'd8, v); check("R9 partial lane write", v, 32'hFFFF_CCFF);

      // R8 counter write while stopped, constant write leaves counter
      wr(8'd12, 32'h77, 4'b1111);
      rd(8'd12, v); check("R8 counter write stopped", v, 32'h77);
      wr(8'd8, 32'h500, 4'b1111);
      rd(8'd12, v); check("R8 constant write keeps counter", v, 32'h77);

      // R4 taps
      step_test("R4 code0 div4", 3'd0, 10);
      step_test("R4 code1 div16", 3'd1, 3);
      step_test("R4 code4 div1024", 3'd4, 1);
      step_test("R4 reserved code6 as div4", 3'd6, 5);

      // R3 stopped channel holds
      repeat (40) @(posedge clk);
      rd(8'd12, v); check("R3 stopped holds", v, 32'd995);

      // R5 reload and flag
      wr(8'd16, 32'd0, 4'b1111);
      wr(8'd8, 32'd5, 4'b1111);
      wr(8'd12, 32'd2, 4'b1111);
      run_for(3'b001, 16);
      rd(8'd12, v); check("R5 reload from constant", v, 32'd4);
      rd(8'd16, v); check("R5 flag set", v, 32'h100);

      // R7 enable gate
      check("R7 irq low without enable", {29'd0, irq}, 32'd0);
      wr(8'd16, 32'h120, 4'b1111);
      check("R7 irq with enable", {29'd0, irq}, 32'd1);

      // R6 flag writes
      wr(8'd16, 32'h120, 4'b1111);
      rd(8'd16, v); check("R6 writing 1 keeps flag", v, 32'h120);
      wr(8'd16, 32'h020, 4'b1111);
      rd(8'd16, v); check("R6 writing 0 clears flag", v, 32'h020);
      check("R6 irq drops after clear", {29'd0, irq}, 32'd0);

      // R3 independent channel, underflow from zero
      wr(8'd28, 32'h20, 4'b1111);
      wr(8'd20, 32'd3, 4'b1111);
      wr(8'd24, 32'd0, 4'b1111);
      run_for(3'b010, 4);
      rd(8'd24, v); check("R3 channel 1 reloaded", v, 32'd3);
      check("R3 only channel 1 interrupts", {29'd0, irq}, 32'd2);
      rd(8'd12, v); check("R3 channel 0 untouched", v, 32'd4);

      // R6 clear racing with underflow: run ch1 at counter 0 and clear repeatedly
      wr(8'd24, 32'd0, 4'b1111);
      wr(8'd4, 32'd2, 4'b0001);
      for (int i = 0; i < 6; i++) wr(8'd28, 32'h20, 4'b0010);
      wr(8'd4, 32'd0, 4'b0001);
      repeat (4) @(posedge clk);

      // R10 alternate layout
      ard(8'd0, v); check("R10 alt start reset", v, 32'd0);
      awr(8'd0, 32'h0003_0000, 4'b0100);
      ard(8'd0, v); check("R10 alt start lane 2", v, 32'h0003_0000);
      awr(8'd0, 32'h0000_00FF, 4'b0001);
      ard(8'd0, v); check("R10 alt other lane ignored", v, 32'h0003_0000);
      awr(8'd0, 32'd0, 4'b0100);
      ard(8'd4, v); check("R10 alt channel 0 constant", v, 32'hFFFF_FFFF);
      awr(8'd16, 32'h0000_CAFE, 4'b1111);
      ard(8'd16, v); check("R10 alt channel 1 constant", v, 32'h0000_CAFE);

      @(negedge clk);
      cmp_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule